// File: doc/BRIEF.md
# Configurable Manchester Serial Transmitter

This block serialises one parallel data word per frame onto a single output line. A frame is a low start cell, then the data cells, then one or two high stop cells. An external divider supplies `bit_tick`, a one-cycle strobe at twice the bit rate. Every cell therefore spans two tick periods, called the first and second half of the cell. In plain NRZ coding both halves of a cell carry the same level. In biphase Manchester coding the two halves are opposite, so every cell has an edge at its centre. This suits two-wire lighting-control style links.

Words enter through a valid/ready stream port. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while no frame is in progress. The source may hold `in_valid` high with a stable word for as long as it needs. Nothing is taken while a frame is on the line, so a word offered during a frame waits and is never dropped by the block.

The configuration pins are sampled on the accepting edge and held for the rest of the frame. An extended-mode enable gates the wide data sizes, the bit-order choice and Manchester coding. With it low, the block is a plain 8-bit, LSB-first NRZ transmitter. The stop-cell count is honoured in both modes.

Top module: `mcx_serial_tx`

## Requirements
- R1: After reset and between frames, `ser_out` is high, `busy` and `done` are low and `in_ready` is high.
- R2: A word is accepted on an edge where `in_valid` and `in_ready` are both high, and `busy` rises on that edge. While `busy` is high, `in_ready` is low, and a word offered then is neither taken nor transmitted.
- R3: In NRZ coding, the frame is a start cell at level 0, then the data cells, then the stop cells at level 1. Each cell keeps one level for two `bit_tick` periods.
- R4: With `ext_en` high, `width_sel` (the data-bit count, an unsigned number) selects 5, 6, 7, 8, 9, 13, 14, 15, 16 or 17 data cells.
- R5: With `ext_en` high, a `width_sel` value of 10, 11 or 12, or one below 5 or above 17, gives 8 data cells.
- R6: With `ext_en` high and `msb_first` high, the data cells run from bit width-1 down to bit 0. With `msb_first` low, they run from bit 0 upward.
- R7: `two_stop` high sends two stop cells. `two_stop` low sends one.
- R8: With `ext_en` and `manch_en` both high, every cell of the frame (start 0, data, stop 1) is coded biphase. A 1 is low in the first half and high in the second half. A 0 is high in the first half and low in the second half.
- R9: With `ext_en` low, the frame carries `in_data[7:0]` LSB-first in NRZ. The values of `width_sel`, `msb_first` and `manch_en` have no effect.
- R10: `done` is high for exactly one cycle. It follows the clock edge on which the `bit_tick` closing the last stop cell's second half is taken, and `busy` falls on that same edge.
- R11: Configuration pins changed after the accepting edge do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can take a word (idle) |
| in_data | input | 17 | Data word, bit 0 is the least significant |
| ext_en | input | 1 | Enables extended sizes, order and Manchester |
| width_sel | input | 5 | Data-bit count in extended mode |
| msb_first | input | 1 | Most significant data bit first |
| manch_en | input | 1 | Biphase Manchester coding |
| two_stop | input | 1 | Two stop cells instead of one |
| bit_tick | input | 1 | Half-bit strobe from the external divider |
| ser_out | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions assume that `bit_tick` is a single-cycle strobe and that `in_data` and the configuration pins hold steady while `in_valid` waits for `in_ready`. The stimulus raises `bit_tick` for one cycle in every four. It changes the data and configuration only on cycles where the handshake cannot complete: before raising `in_valid`, or after the accepting edge, when it deliberately scrambles the configuration to test R11. Words are also offered during frames, always withdrawn before the frame ends, to show they are not taken.

// File: rtl/mcx_pkg.sv
package mcx_pkg;

  // Largest data word the transmitter handles.
  localparam int unsigned MAX_DATA_W = 17;
  // Width of the data-bit-count selector.
  localparam int unsigned SEL_W = 5;
  // Data-bit count used whenever the selector is unusable or extended mode is off.
  localparam int unsigned FALLBACK_W = 8;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_SEND = 1'b1
  } seq_state_e;

  // Resolved per-frame settings.
  typedef struct packed {
    logic [SEL_W-1:0] width;
    logic             msb;
    logic             manch;
    logic             two_stop;
  } frame_cfg_t;

  // Returns 1 when the count is one of the supported sizes.
  function automatic logic width_legal(input logic [SEL_W-1:0] w);
    logic ok;
    ok = 1'b0;
    if (w >= SEL_W'(5) && w <= SEL_W'(9)) ok = 1'b1;
    if (w >= SEL_W'(13) && w <= SEL_W'(MAX_DATA_W)) ok = 1'b1;
    return ok;
  endfunction

endpackage

// File: rtl/mcx_cfg_resolve.sv
module mcx_cfg_resolve
  import mcx_pkg::*;
#(
  parameter int unsigned WSEL_W = SEL_W
) (
  input  logic              ext_en,
  input  logic [WSEL_W-1:0] width_sel,
  input  logic              msb_first,
  input  logic              manch_en,
  input  logic              two_stop,
  output frame_cfg_t        cfg
);

  always_comb begin
    cfg.two_stop = two_stop;
    if (ext_en) begin
      cfg.width = width_legal(width_sel) ? width_sel : WSEL_W'(FALLBACK_W);
      cfg.msb   = msb_first;
      cfg.manch = manch_en;
    end else begin
      cfg.width = WSEL_W'(FALLBACK_W);
      cfg.msb   = 1'b0;
      cfg.manch = 1'b0;
    end
  end

endmodule

// File: rtl/mcx_frame_seq.sv
module mcx_frame_seq
  import mcx_pkg::*;
#(
  parameter int unsigned WSEL_W = SEL_W,
  parameter int unsigned CELL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic [WSEL_W-1:0] width,
  input  logic              two_stop,
  output logic              busy,
  output logic              done,
  output logic [CELL_W-1:0] cell_idx,
  output logic              half
);

  seq_state_e        state_q;
  logic [WSEL_W-1:0] width_q;
  logic              two_q;
  logic [CELL_W-1:0] last_cell;

  // Index of the final stop cell: start(0) + data cells + stop cells.
  always_comb begin
    last_cell = CELL_W'(width_q) + (two_q ? CELL_W'(2) : CELL_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      width_q  <= '0;
      two_q    <= 1'b0;
      cell_idx <= '0;
      half     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q  <= SEQ_SEND;
            width_q  <= width;
            two_q    <= two_stop;
            cell_idx <= '0;
            half     <= 1'b0;
          end
        end
        SEQ_SEND: begin
          if (tick) begin
            if (!half) begin
              half <= 1'b1;
            end else begin
              half <= 1'b0;
              if (cell_idx == last_cell) begin
                state_q  <= SEQ_IDLE;
                cell_idx <= '0;
                done     <= 1'b1;
              end else begin
                cell_idx <= cell_idx + CELL_W'(1);
              end
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state_q == SEQ_SEND);

endmodule

// File: rtl/mcx_line_enc.sv
module mcx_line_enc
  import mcx_pkg::*;
#(
  parameter int unsigned DATA_W = MAX_DATA_W,
  parameter int unsigned WSEL_W = SEL_W,
  parameter int unsigned CELL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  frame_cfg_t        cfg,
  input  logic              busy,
  input  logic [CELL_W-1:0] cell_idx,
  input  logic              half,
  output logic              manch_q,
  output logic              line
);

  logic [DATA_W-1:0] data_q;
  logic [WSEL_W-1:0] width_q;
  logic              msb_q;
  logic [CELL_W-1:0] data_k;
  logic [WSEL_W-1:0] bit_pos;
  logic              cell_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      width_q <= '0;
      msb_q   <= 1'b0;
      manch_q <= 1'b0;
    end else if (load) begin
      data_q  <= data_in;
      width_q <= cfg.width;
      msb_q   <= cfg.msb;
      manch_q <= cfg.manch;
    end
  end

  // Level carried by the current cell.
  always_comb begin
    data_k  = cell_idx - CELL_W'(1);
    bit_pos = msb_q ? (width_q - WSEL_W'(1) - WSEL_W'(data_k)) : WSEL_W'(data_k);
    if (cell_idx == '0) begin
      cell_val = 1'b0;
    end else if (cell_idx <= CELL_W'(width_q)) begin
      cell_val = data_q[bit_pos];
    end else begin
      cell_val = 1'b1;
    end
  end

  // NRZ holds the level, biphase sends the complement first.
  always_comb begin
    if (!busy) begin
      line = 1'b1;
    end else if (manch_q) begin
      line = half ? cell_val : ~cell_val;
    end else begin
      line = cell_val;
    end
  end

endmodule

// File: rtl/mcx_serial_tx.sv
module mcx_serial_tx
  import mcx_pkg::*;
#(
  parameter int unsigned DATA_W = MAX_DATA_W,
  parameter int unsigned WSEL_W = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ext_en,
  input  logic [WSEL_W-1:0] width_sel,
  input  logic              msb_first,
  input  logic              manch_en,
  input  logic              two_stop,
  input  logic              bit_tick,
  output logic              ser_out,
  output logic              busy,
  output logic              done
);

  localparam int unsigned CELL_W = $clog2(DATA_W + 4);

  frame_cfg_t        cfg_now;
  logic              accept;
  logic [CELL_W-1:0] seq_cell;
  logic              seq_half;
  logic              enc_manch;

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  mcx_cfg_resolve #(.WSEL_W(WSEL_W)) u_cfg (
    .ext_en    (ext_en),
    .width_sel (width_sel),
    .msb_first (msb_first),
    .manch_en  (manch_en),
    .two_stop  (two_stop),
    .cfg       (cfg_now)
  );

  mcx_frame_seq #(.WSEL_W(WSEL_W), .CELL_W(CELL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .tick     (bit_tick),
    .width    (cfg_now.width),
    .two_stop (cfg_now.two_stop),
    .busy     (busy),
    .done     (done),
    .cell_idx (seq_cell),
    .half     (seq_half)
  );

  mcx_line_enc #(.DATA_W(DATA_W), .WSEL_W(WSEL_W), .CELL_W(CELL_W)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .data_in  (in_data),
    .cfg      (cfg_now),
    .busy     (busy),
    .cell_idx (seq_cell),
    .half     (seq_half),
    .manch_q  (enc_manch),
    .line     (ser_out)
  );

endmodule

// File: rtl/mcx_serial_tx_chk.sv
module mcx_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic bit_tick,
  input logic ser_out,
  input logic busy,
  input logic done,
  input logic half,
  input logic manch_q
);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_out);

  a_r2_take_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  a_r2_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> (busy && $stable(ser_out)));

  a_r3_nrz_flat_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_tick && !half && !manch_q) |=> $stable(ser_out));

  a_r8_mid_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_tick && !half && manch_q) |=> (ser_out != $past(ser_out)));

  a_r10_done_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(bit_tick)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind mcx_serial_tx mcx_serial_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .bit_tick (bit_tick),
  .ser_out  (ser_out),
  .busy     (busy),
  .done     (done),
  .half     (seq_half),
  .manch_q  (enc_manch)
);

// File: tb/mcx_serial_tx_tb_top.sv
module mcx_serial_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [16:0] in_data = '0;
  logic        ext_en = 1'b0;
  logic [4:0]  width_sel = 5'd8;
  logic        msb_first = 1'b0;
  logic        manch_en = 1'b0;
  logic        two_stop = 1'b0;
  logic        bit_tick = 1'b0;
  logic        ser_out;
  logic        busy;
  logic        done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [63:0] exp_q[$];
  int          len_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  mcx_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ext_en(ext_en), .width_sel(width_sel),
    .msb_first(msb_first), .manch_en(manch_en), .two_stop(two_stop),
    .bit_tick(bit_tick), .ser_out(ser_out), .busy(busy), .done(done)
  );

  // Half-bit strobe: one cycle high in every four.
  initial begin
    int n;
    n = 0;
    forever begin
      @(posedge clk);
      n = (n + 1) % 4;
      bit_tick <= (n == 0);
    end
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // Expected half-cell sequence, computed from the requirements.
  task automatic build(input logic [16:0] d, input logic ext, input logic [4:0] ws,
                       input logic msb, input logic man, input logic two,
                       output logic [63:0] v, output int len);
    int w;
    int ncell;
    logic cells [0:19];
    w = 8;
    if (ext && ((ws >= 5 && ws <= 9) || (ws >= 13 && ws <= 17))) w = int'(ws);
    cells[0] = 1'b0;
    for (int i = 0; i < w; i++)
      cells[1+i] = (ext && msb) ? d[w-1-i] : d[i];
    cells[1+w] = 1'b1;
    ncell = w + 2;
    if (two) begin
      cells[ncell] = 1'b1;
      ncell++;
    end
    v = '0;
    for (int c = 0; c < ncell; c++) begin
      v[2*c]   = (ext && man) ? ~cells[c] : cells[c];
      v[2*c+1] = cells[c];
    end
    len = 2 * ncell;
  endtask

  // Driver: offer a word, push its expectation, scramble config after the take.
  task automatic send(input string tag, input logic [16:0] d, input logic ext,
                      input logic [4:0] ws, input logic msb, input logic man,
                      input logic two, input bit poke);
    logic [63:0] v;
    int len;
    @(negedge clk);
    in_data = d; ext_en = ext; width_sel = ws; msb_first = msb;
    manch_en = man; two_stop = two; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    build(d, ext, ws, msb, man, two, v, len);
    exp_q.push_back(v); len_q.push_back(len); tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    // R11: configuration changes mid-frame must not matter.
    ext_en = ~ext; width_sel = 5'd13; msb_first = ~msb; manch_en = ~man;
    two_stop = ~two; in_data = ~d;
    if (poke) begin
      // R2: a word offered while busy must not be taken.
      in_valid = 1'b1;
      for (int i = 0; i < 6; i++) begin
        check("R2 in_ready low while busy", {63'd0, in_ready}, 64'd0);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
  endtask

  // Monitor: collect one line sample per half cell, compare at done.
  initial begin
    logic [63:0] got;
    int n;
    bit prev_done;
    got = '0; n = 0; prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done) begin
          if (prev_done) check("R10 done one cycle", 64'd1, 64'd0);
          check("R10 busy low with done", {63'd0, busy}, 64'd0);
          if (exp_q.size() == 0) begin
            check("R2 unexpected frame", 64'd1, 64'd0);
          end else begin
            logic [63:0] e;
            int l;
            string t;
            e = exp_q.pop_front(); l = len_q.pop_front(); t = tag_q.pop_front();
            check({t, " length"}, 64'(n), 64'(l));
            check(t, got, e);
          end
          got = '0; n = 0;
        end
        if (busy && bit_tick) begin
          if (n < 64) got[n] = ser_out;
          n++;
        end
        prev_done = done;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ser_out idle", {63'd0, ser_out}, 64'd1);
    check("R1 busy idle", {63'd0, busy}, 64'd0);
    check("R1 done idle", {63'd0, done}, 64'd0);
    check("R1 in_ready idle", {63'd0, in_ready}, 64'd1);

    send("R9 plain 8-bit ignores ext fields", 17'h1_F0A5, 1'b0, 5'd17, 1'b1, 1'b1, 1'b0, 1'b0);
    send("R7 plain two stop", 17'h0_003C, 1'b0, 5'd5, 1'b0, 1'b1, 1'b1, 1'b0);
    send("R4 width 5 lsb", 17'h0_0013, 1'b1, 5'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    send("R6 width 9 msb", 17'h0_0135, 1'b1, 5'd9, 1'b1, 1'b0, 1'b0, 1'b1);
    send("R4 width 13", 17'h0_1ACE, 1'b1, 5'd13, 1'b0, 1'b0, 1'b1, 1'b0);
    send("R4 width 14 msb", 17'h0_2BCD, 1'b1, 5'd14, 1'b1, 1'b0, 1'b0, 1'b0);
    send("R4 width 15", 17'h0_5A5A, 1'b1, 5'd15, 1'b0, 1'b0, 1'b0, 1'b0);
    send("R4 width 16 msb", 17'h0_8001, 1'b1, 5'd16, 1'b1, 1'b0, 1'b1, 1'b0);
    send("R4 width 17", 17'h1_2345, 1'b1, 5'd17, 1'b0, 1'b0, 1'b0, 1'b0);
    send("R5 width 11 falls back", 17'h1_FF96, 1'b1, 5'd11, 1'b0, 1'b0, 1'b0, 1'b0);
    send("R5 width 20 falls back", 17'h0_0C3A, 1'b1, 5'd20, 1'b1, 1'b0, 1'b0, 1'b0);
    send("R5 width 3 falls back", 17'h0_0077, 1'b1, 5'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    send("R8 manchester 8", 17'h0_00B2, 1'b1, 5'd8, 1'b0, 1'b1, 1'b0, 1'b1);
    send("R8 manchester 17 msb two stop", 17'h1_6D29, 1'b1, 5'd17, 1'b1, 1'b1, 1'b1, 1'b0);
    send("R3 nrz width 6 after manchester", 17'h0_002D, 1'b1, 5'd6, 1'b0, 1'b0, 1'b0, 1'b0);

    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R1 ser_out idle after frames", {63'd0, ser_out}, 64'd1);
    check("R2 no extra frame", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule